// File: doc/BRIEF.md
# Dual-Byte Instruction Fetch Unit

This block is the fetch front end of an 8-bit microcontroller core whose instructions are one, two or three bytes long. Program memory answers every read with a pair of bytes from an even address. The unit keeps the bytes it has not yet used in a small buffer. It finds each instruction's length from its first byte and hands the decoder one complete instruction at a time over a valid/ready channel, together with its address and length.

The execution stage shares the same memory port. It can read single bytes from code space, and those reads return on a separate response channel. It can also write bytes into code space. These code-space requests win the port over instruction fetch. A redirect input (jump, call, return or interrupt vector) empties the buffer, drops any fetch read still in flight, and restarts fetch at the new address. If the address is odd, the unused first byte of the returned pair is dropped. Interrupt-pending state is sampled only when an instruction is handed over, because that is the only point where a vector could be taken.

Top module: `dual_byte_fetch`

## Requirements
- R1: After a synchronous active-low reset, `ins_valid` is 0, `irq_seen` is 0, and the unit at once requests a fetch read at address 0x0000.
- R2: The buffer holds four bytes, and a fetch read is issued only when at least two slots are free. With the decoder stalled after a redirect to any target, exactly two fetch reads are issued.
- R3: Instruction length comes from opcode bits [1:0]: 2'b00 gives 1 byte, 2'b01 gives 2, 2'b10 gives 3 and 2'b11 gives 1. `ins_len` carries that length.
- R4: `ins_bytes[7:0]` holds the opcode and `ins_bytes[15:8]` and `ins_bytes[23:16]` hold the following bytes; bytes beyond the length read as zero. `ins_pc` is the opcode address, and each accepted instruction advances it by its length, modulo 64 KB. While `ins_ready` is low, the offered instruction holds.
- R5: A fetch read goes out with `mem_req_write`=0 and an even address. The response carries the byte at that address in bits [7:0] and the next byte in [15:8]. Successive fetch addresses step by two and wrap at 0xFFFF.
- R6: In a cycle with `redirect_valid` high, no instruction is offered. The buffer empties, any fetch response still outstanding is discarded, and the next instruction offered starts at the target. With an odd target, the first byte of the first pair is dropped.
- R7: When a code-space request and a fetch compete, the code-space request takes the port. A code read of address A returns the byte at A on `cd_rsp_data` with `cd_rsp_valid`, whatever redirects occur in between.
- R8: A code write appears on the memory port with `mem_req_write`=1 and the requested address and data, and it expects no response. A later code read of that address returns the written byte.
- R9: `irq_rd` is high only in cycles where an instruction transfer completes. `irq_seen` holds the `irq_pend` value from the most recent such transfer and does not change otherwise.
- R10: At most one memory read is outstanding. No request is made from the cycle a read is accepted until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| redirect_valid | input | 1 | Restart fetch at `redirect_target` |
| redirect_target | input | 16 | New fetch address |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = code write, 0 = pair read |
| mem_req_addr | output | 16 | Request byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 16 | Byte pair, even address in [7:0] |
| cd_req_valid | input | 1 | Code-space request from execution |
| cd_req_ready | output | 1 | Code-space request accepted |
| cd_req_write | input | 1 | 1 = write, 0 = read |
| cd_req_addr | input | 16 | Code-space byte address |
| cd_req_wdata | input | 8 | Code-space write data |
| cd_rsp_valid | output | 1 | Code read data present |
| cd_rsp_data | output | 8 | Code read byte |
| ins_valid | output | 1 | Complete instruction offered |
| ins_ready | input | 1 | Decoder takes the instruction |
| ins_bytes | output | 24 | Instruction bytes, opcode lowest |
| ins_len | output | 2 | Instruction length in bytes |
| ins_pc | output | 16 | Opcode address |
| irq_pend | input | 1 | Interrupt-pending state |
| irq_rd | output | 1 | Interrupt state sampled this cycle |
| irq_seen | output | 1 | Pending state from the last boundary |

## Verification
The hardest case to reach is a redirect that lands while a fetch read is still in flight. It is hardest when the stale pair returns in the same cycle as the redirect, or while a code read holds the port. The stimulus reaches it with random memory latency of one to three cycles, random port acceptance and random decoder stalls. Redirects are issued every sixty cycles to forty-eight targets, odd, even and just below the wrap point. Two fully stalled phases, one after an even target and one after an odd target, pin down the exact number of fetch reads the buffer allows.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

   localparam int BYTE_W = 8;
   localparam int MAX_LEN = 3;

   typedef enum logic {
      SRC_FETCH = 1'b0,
      SRC_CODE  = 1'b1
   } port_src_e;

   // opcode bits [1:0]: 00 -> 1, 01 -> 2, 10 -> 3, 11 -> 1
   function automatic logic [1:0] op_length(input logic [BYTE_W-1:0] op);
      unique case (op[1:0])
         2'b01:   return 2'd2;
         2'b10:   return 2'd3;
         default: return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/fetch_byte_queue.sv
module fetch_byte_queue #(
   parameter int DEPTH = 4,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [1:0]    push_n,
   input  logic [15:0]   push_data,
   input  logic [1:0]    pop_n,
   output logic [23:0]   head_o,
   output logic [CW-1:0] count_o
);
   localparam int IW = $clog2(DEPTH);

   logic [7:0]    slot_q [DEPTH];
   logic [7:0]    slot_d [DEPTH];
   logic [CW-1:0] cnt_q;

   always_comb begin
      int keep;
      int src;
      keep = int'(cnt_q) - int'(pop_n);
      for (int i = 0; i < DEPTH; i++) begin
         src = i + int'(pop_n);
         if (src < int'(cnt_q) && src < DEPTH)
            slot_d[i] = slot_q[IW'(src)];
         else if (i == keep && push_n != 2'd0)
            slot_d[i] = push_data[7:0];
         else if (i == keep + 1 && push_n == 2'd2)
            slot_d[i] = push_data[15:8];
         else
            slot_d[i] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else begin
         cnt_q <= cnt_q - CW'(pop_n) + CW'(push_n);
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
      end
   end

   for (genvar j = 0; j < 3; j++) begin : g_head
      assign head_o[8*j +: 8] = slot_q[j];
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/fetch_ins_pack.sv
module fetch_ins_pack
   import fetch_pkg::*;
#(
   parameter int CW = 3
) (
   input  logic [23:0]   head,
   input  logic [CW-1:0] count,
   input  logic          hold_off,
   output logic          avail,
   output logic [1:0]    len,
   output logic [23:0]   bytes
);
   assign len   = op_length(head[7:0]);
   assign avail = !hold_off && (count != '0) && (count >= CW'(len));

   for (genvar j = 0; j < MAX_LEN; j++) begin : g_mask
      assign bytes[8*j +: 8] = (2'(j) < len) ? head[8*j +: 8] : 8'h00;
   end
endmodule

// File: rtl/fetch_port_arb.sv
module fetch_port_arb
   import fetch_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter bit CODE_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect,
   input  logic              fetch_want,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_issued,
   output logic              fetch_rsp_valid,
   input  logic              cd_valid,
   input  logic              cd_write,
   input  logic [ADDR_W-1:0] cd_addr,
   input  logic [7:0]        cd_wdata,
   output logic              cd_ready,
   output logic              cd_rsp_valid,
   output logic [7:0]        cd_rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [7:0]        mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [15:0]       mem_rsp_data,
   output logic              busy
);
   logic      out_q, drop_q, odd_q;
   port_src_e src_q;
   logic      pick_code;

   if (CODE_FIRST) begin : g_code_first
      assign pick_code = cd_valid;
   end else begin : g_fetch_first
      assign pick_code = cd_valid && !fetch_want;
   end

   assign mem_req_valid = !out_q && (cd_valid || fetch_want);
   assign mem_req_write = pick_code && cd_write;
   assign mem_req_addr  = pick_code ? cd_addr : fetch_addr;
   assign mem_req_wdata = pick_code ? cd_wdata : 8'h00;

   assign cd_ready      = !out_q && pick_code && mem_req_ready;
   assign fetch_issued  = !out_q && !pick_code && fetch_want && mem_req_ready;

   assign fetch_rsp_valid = mem_rsp_valid && out_q && (src_q == SRC_FETCH)
                            && !drop_q && !redirect;
   assign cd_rsp_valid    = mem_rsp_valid && out_q && (src_q == SRC_CODE);
   assign cd_rsp_data     = odd_q ? mem_rsp_data[15:8] : mem_rsp_data[7:0];
   assign busy            = out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q  <= 1'b0;
         drop_q <= 1'b0;
         odd_q  <= 1'b0;
         src_q  <= SRC_FETCH;
      end else begin
         if (out_q && mem_rsp_valid) begin
            out_q <= 1'b0;
         end else if (mem_req_valid && mem_req_ready && !mem_req_write) begin
            out_q  <= 1'b1;
            src_q  <= pick_code ? SRC_CODE : SRC_FETCH;
            odd_q  <= cd_addr[0];
            drop_q <= 1'b0;
         end
         if (redirect && out_q && !mem_rsp_valid && src_q == SRC_FETCH)
            drop_q <= 1'b1;
      end
   end
endmodule

// File: rtl/dual_byte_fetch.sv
module dual_byte_fetch
   import fetch_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DEPTH      = 4,
   parameter bit CODE_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect_valid,
   input  logic [ADDR_W-1:0] redirect_target,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [7:0]        mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [15:0]       mem_rsp_data,
   input  logic              cd_req_valid,
   output logic              cd_req_ready,
   input  logic              cd_req_write,
   input  logic [ADDR_W-1:0] cd_req_addr,
   input  logic [7:0]        cd_req_wdata,
   output logic              cd_rsp_valid,
   output logic [7:0]        cd_rsp_data,
   output logic              ins_valid,
   input  logic              ins_ready,
   output logic [23:0]       ins_bytes,
   output logic [1:0]        ins_len,
   output logic [ADDR_W-1:0] ins_pc,
   input  logic              irq_pend,
   output logic              irq_rd,
   output logic              irq_seen
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 4) begin : g_bad_depth
      $error("dual_byte_fetch: DEPTH must be at least 4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("dual_byte_fetch: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] pc_q, fa_q;
   logic              skip_q, irq_q;
   logic [CW-1:0]     q_count;
   logic [23:0]       head;
   logic              fetch_want, fetch_issued, fetch_rsp_valid, busy, hs;
   logic [1:0]        push_n, pop_n;
   logic [15:0]       push_data;

   assign fetch_want = (q_count <= CW'(DEPTH - 2)) && !redirect_valid;
   assign hs         = ins_valid && ins_ready;
   assign pop_n      = hs ? ins_len : 2'd0;
   assign push_n     = fetch_rsp_valid ? (skip_q ? 2'd1 : 2'd2) : 2'd0;
   assign push_data  = skip_q ? {8'h00, mem_rsp_data[15:8]} : mem_rsp_data;

   fetch_byte_queue #(.DEPTH(DEPTH), .CW(CW)) u_queue (
      .clk(clk), .rst_n(rst_n), .flush(redirect_valid),
      .push_n(push_n), .push_data(push_data), .pop_n(pop_n),
      .head_o(head), .count_o(q_count)
   );

   fetch_ins_pack #(.CW(CW)) u_pack (
      .head(head), .count(q_count), .hold_off(redirect_valid),
      .avail(ins_valid), .len(ins_len), .bytes(ins_bytes)
   );

   fetch_port_arb #(.ADDR_W(ADDR_W), .CODE_FIRST(CODE_FIRST)) u_arb (
      .clk(clk), .rst_n(rst_n), .redirect(redirect_valid),
      .fetch_want(fetch_want), .fetch_addr(fa_q),
      .fetch_issued(fetch_issued), .fetch_rsp_valid(fetch_rsp_valid),
      .cd_valid(cd_req_valid), .cd_write(cd_req_write), .cd_addr(cd_req_addr),
      .cd_wdata(cd_req_wdata), .cd_ready(cd_req_ready),
      .cd_rsp_valid(cd_rsp_valid), .cd_rsp_data(cd_rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .busy(busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= '0;
         fa_q   <= '0;
         skip_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (redirect_valid) begin
            pc_q   <= redirect_target;
            fa_q   <= {redirect_target[ADDR_W-1:1], 1'b0};
            skip_q <= redirect_target[0];
         end else begin
            if (hs)              pc_q   <= pc_q + ADDR_W'(ins_len);
            if (fetch_issued)    fa_q   <= fa_q + ADDR_W'(2);
            if (fetch_rsp_valid) skip_q <= 1'b0;
         end
         if (hs) irq_q <= irq_pend;
      end
   end

   assign ins_pc   = pc_q;
   assign irq_rd   = hs;
   assign irq_seen = irq_q;
endmodule

// File: rtl/fetch_checker.sv
module fetch_checker #(
   parameter int ADDR_W     = 16,
   parameter int DEPTH      = 4,
   parameter int CW         = 3,
   parameter bit CODE_FIRST = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              redirect_valid,
   input logic              mem_req_valid,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              cd_req_valid,
   input logic [ADDR_W-1:0] cd_req_addr,
   input logic              ins_valid,
   input logic              ins_ready,
   input logic [23:0]       ins_bytes,
   input logic [ADDR_W-1:0] ins_pc,
   input logic              irq_rd,
   input logic              irq_seen,
   input logic [CW-1:0]     q_count,
   input logic              busy
);
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !mem_req_valid);

   a_r5_fetch_even: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !cd_req_valid) |-> (!mem_req_addr[0] && !mem_req_write));

   if (CODE_FIRST) begin : g_prio
      a_r7_code_first: assert property (@(posedge clk) disable iff (!rst_n)
         (cd_req_valid && mem_req_valid) |-> (mem_req_addr == cd_req_addr));
   end

   a_r9_irq_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rd |-> (ins_valid && ins_ready));

   a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_rd |=> $stable(irq_seen));

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !ins_ready) |=>
         (redirect_valid || (ins_valid && $stable(ins_bytes) && $stable(ins_pc))));

   a_r6_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> !ins_valid);

   a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> (q_count == '0));
endmodule

bind dual_byte_fetch fetch_checker #(
   .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CW($clog2(DEPTH + 1)), .CODE_FIRST(CODE_FIRST)
) u_fetch_checker (
   .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid),
   .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
   .mem_req_addr(mem_req_addr), .cd_req_valid(cd_req_valid),
   .cd_req_addr(cd_req_addr), .ins_valid(ins_valid), .ins_ready(ins_ready),
   .ins_bytes(ins_bytes), .ins_pc(ins_pc), .irq_rd(irq_rd), .irq_seen(irq_seen),
   .q_count(q_count), .busy(busy)
);

// File: tb/test_dual_byte_fetch.sv
`timescale 1ns/1ps
module test_dual_byte_fetch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        redirect_valid = 1'b0;
   logic [15:0] redirect_target = '0;
   logic        mem_req_valid, mem_req_write;
   logic        mem_req_ready = 1'b0;
   logic [15:0] mem_req_addr;
   logic [7:0]  mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [15:0] mem_rsp_data = '0;
   logic        cd_req_valid = 1'b0, cd_req_write = 1'b0;
   logic        cd_req_ready;
   logic [15:0] cd_req_addr = '0;
   logic [7:0]  cd_req_wdata = '0;
   logic        cd_rsp_valid;
   logic [7:0]  cd_rsp_data;
   logic        ins_valid;
   logic        ins_ready = 1'b0;
   logic [23:0] ins_bytes;
   logic [1:0]  ins_len;
   logic [15:0] ins_pc;
   logic        irq_pend = 1'b0;
   logic        irq_rd, irq_seen;

   dual_byte_fetch i_dual_byte_fetch (
      .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid),
      .redirect_target(redirect_target), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .cd_req_valid(cd_req_valid), .cd_req_ready(cd_req_ready),
      .cd_req_write(cd_req_write), .cd_req_addr(cd_req_addr),
      .cd_req_wdata(cd_req_wdata), .cd_rsp_valid(cd_rsp_valid),
      .cd_rsp_data(cd_rsp_data), .ins_valid(ins_valid), .ins_ready(ins_ready),
      .ins_bytes(ins_bytes), .ins_len(ins_len), .ins_pc(ins_pc),
      .irq_pend(irq_pend), .irq_rd(irq_rd), .irq_seen(irq_seen)
   );

   always #4 clk = ~clk;

   int          n_tests = 0;
   int          n_fail  = 0;
   logic [7:0]  wmem [256];
   bit   [255:0] wset = '0;
   logic [15:0] exp_pc = '0;
   logic        exp_irq = 1'b0;
   bit          pend_read = 0;
   int          rsp_wait = 0;
   logic [15:0] rsp_pair = '0;
   bit          rsp_is_cd = 0;
   bit          cd_active = 0, cd_w = 0, cd_wait_rsp = 0, rnd_cd = 0;
   logic [15:0] cd_a = '0;
   logic [7:0]  cd_d = '0, cd_exp = '0;
   int          fetch_hs = 0;

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic logic [7:0] byte_at(input logic [15:0] a);
      if (a[15:8] == 8'hFF && wset[a[7:0]]) return wmem[a[7:0]];
      return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic int len_of(input logic [7:0] op);
      case (op[1:0])
         2'b01:   return 2;
         2'b10:   return 3;
         default: return 1;
      endcase
   endfunction

   function automatic logic [23:0] exp_bytes(input logic [15:0] p, input int n);
      logic [23:0] r = '0;
      for (int i = 0; i < n; i++) r[8*i +: 8] = byte_at(p + 16'(i));
      return r;
   endfunction

   // one clock cycle, entered and left at a falling edge
   task automatic cyc(input bit redir, input logic [15:0] tgt, input bit stall);
      bit busy_now;
      int n;
      redirect_valid  = redir;
      redirect_target = tgt;
      ins_ready       = stall ? 1'b0 : ($urandom % 4 != 0);
      mem_req_ready   = ($urandom % 4 != 0);
      irq_pend        = 1'($urandom % 2);
      if (rnd_cd && !cd_active && !cd_wait_rsp && ($urandom % 6 == 0)) begin
         cd_active = 1; cd_w = 0; cd_a = 16'($urandom) & 16'hFEFF;
      end
      cd_req_valid = cd_active; cd_req_write = cd_w;
      cd_req_addr  = cd_a;      cd_req_wdata = cd_d;
      mem_rsp_valid = 1'b0;
      busy_now = pend_read;
      if (pend_read) begin
         rsp_wait--;
         if (rsp_wait == 0) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = rsp_pair; pend_read = 0;
         end
      end
      #1;
      if (mem_rsp_valid && rsp_is_cd) begin
         check(cd_rsp_valid && cd_rsp_data == cd_exp,
               (cd_a[15:8] == 8'hFF && wset[cd_a[7:0]]) ? "R8 readback" : "R7 code read",
               {23'd0, cd_rsp_valid, cd_rsp_data}, {24'd1, cd_exp});
         cd_wait_rsp = 0;
      end else if (mem_rsp_valid) begin
         check(!cd_rsp_valid, "R7 no code rsp on fetch rsp", 32'(cd_rsp_valid), 0);
      end
      if (redir) check(!ins_valid, "R6 no offer during redirect", 32'(ins_valid), 0);
      check(irq_rd == (ins_valid && ins_ready), "R9 irq_rd strobe",
            32'(irq_rd), 32'(ins_valid && ins_ready));
      check(irq_seen == exp_irq, "R9 irq_seen", 32'(irq_seen), 32'(exp_irq));
      if (ins_valid && ins_ready) begin
         n = len_of(byte_at(exp_pc));
         check(ins_pc == exp_pc, "R4 ins_pc", 32'(ins_pc), 32'(exp_pc));
         check(int'(ins_len) == n, "R3 length", 32'(ins_len), 32'(n));
         check(ins_bytes == exp_bytes(exp_pc, n), "R4 bytes",
               32'(ins_bytes), 32'(exp_bytes(exp_pc, n)));
         exp_pc  = exp_pc + 16'(n);
         exp_irq = irq_pend;
      end
      if (mem_req_valid && mem_req_ready) begin
         check(!busy_now, "R10 request while read outstanding", 1, 0);
         if (cd_active) begin
            check(cd_req_ready && mem_req_addr == cd_a && mem_req_write == cd_w,
                  "R7 code request takes port", 32'(mem_req_addr), 32'(cd_a));
            if (cd_w) begin
               check(mem_req_wdata == cd_d, "R8 write data",
                     32'(mem_req_wdata), 32'(cd_d));
               wmem[cd_a[7:0]] = cd_d; wset[cd_a[7:0]] = 1'b1;
            end else begin
               cd_exp = byte_at(cd_a); cd_wait_rsp = 1;
               rsp_pair = {byte_at(cd_a | 16'd1), byte_at(cd_a & 16'hFFFE)};
               rsp_is_cd = 1; pend_read = 1; rsp_wait = 1 + int'($urandom % 3);
            end
            cd_active = 0;
         end else begin
            check(!mem_req_write && !mem_req_addr[0], "R5 fetch read even",
                  32'(mem_req_addr), 32'(mem_req_addr & 16'hFFFE));
            fetch_hs++;
            rsp_pair = {byte_at(mem_req_addr | 16'd1), byte_at(mem_req_addr)};
            rsp_is_cd = 0; pend_read = 1; rsp_wait = 1 + int'($urandom % 3);
         end
      end
      if (redir) exp_pc = tgt;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic stall_phase(input logic [15:0] tgt);
      cyc(1, tgt, 1);
      fetch_hs = 0;
      for (int i = 0; i < 24; i++) cyc(0, 16'h0, 1);
      check(fetch_hs == 2, "R2 reads with decoder stalled", 32'(fetch_hs), 2);
      #1;
      check(ins_valid && ins_pc == tgt, "R6 first instruction at target",
            32'(ins_pc), 32'(tgt));
      check(ins_bytes == exp_bytes(tgt, len_of(byte_at(tgt))), "R4 held bytes",
            32'(ins_bytes), 32'(exp_bytes(tgt, len_of(byte_at(tgt)))));
      #0;
   endtask

   initial begin
      #(8 * 150000);
      check(0, "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) wmem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(!ins_valid, "R1 no instruction after reset", 32'(ins_valid), 0);
      check(mem_req_valid && !mem_req_write && mem_req_addr == 16'h0000,
            "R1 first fetch at 0", 32'(mem_req_addr), 0);
      check(!irq_seen, "R1 irq_seen cleared", 32'(irq_seen), 0);
      @(negedge clk);
      // stream from reset: decoder not stalled, so it accepts within 80 cycles
      for (int i = 0; i < 80; i++) cyc(0, 16'h0, 0);
      stall_phase(16'h0100);
      stall_phase(16'h0201);
      rnd_cd = 1;
      for (int k = 0; k < 48; k++) begin
         logic [15:0] t;
         t = (k == 0) ? 16'hFFFB : (16'(k) * 16'h0531 + 16'(k % 2));
         cyc(1, t, 0);
         for (int i = 0; i < 60; i++) cyc(0, 16'h0, 0);
      end
      rnd_cd = 0;
      while (cd_active || cd_wait_rsp || pend_read) cyc(0, 16'h0, 0);
      cyc(1, 16'h2000, 0);
      for (int i = 0; i < 16; i++) begin
         cd_active = 1; cd_w = 1; cd_a = 16'hFF00 + 16'(i * 3); cd_d = 8'(i * 17 + 3);
         while (cd_active) cyc(0, 16'h0, 0);
         cd_active = 1; cd_w = 0;
         while (cd_active || cd_wait_rsp) cyc(0, 16'h0, 0);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule